// File: doc/BRIEF.md
# Padded-Lane Partitioned Adder

This block adds two partitioned operands whose element layouts differ. Operand A is a 16-bit container split into four 4-bit lanes. Each lane carries a 3-bit element in its low three bits and one padding bit on top, which is the layout a 3-bit slice leaves behind. Operand B is a packed 8-bit word of 2-bit elements.

Before the add, each B element is zero-extended to 3 bits and placed at the same bit position as the matching A element. The two are then summed with the carry cut at every element and padding boundary. A 2-bit mode selects how many elements are present: one, two or four. Padding bits and unused lanes of the result are forced to zero.

The sum itself is combinational. It is delivered through a single valid/ready output register so the block can sit in a streaming datapath. An input beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new input is accepted.

Top module: `padded_lane_adder`

## Requirements
- R1: For every active lane i, result bits [4i+2:4i] equal (A bits [4i+2:4i] + zero-extended B bits [2i+1:2i]) modulo 8.
- R2: Mode 2'b00 activates only lane 0 (result bits 2:0); result bits 15:4 are zero.
- R3: Mode 2'b01 activates lanes 0 and 2 (result bits 2:0 and 10:8); lanes 1 and 3 of the result are zero.
- R4: Mode 2'b10 activates all four lanes (result bits 2:0, 6:4, 10:8, 14:12).
- R5: Mode 2'b11 is reserved and yields an all-zero result.
- R6: Result padding bits 3, 7, 11 and 15 are always zero, and A's padding bits have no effect on the result.
- R7: A carry never leaves its element: an overflowing lane wraps, and neighbouring lanes are unaffected.
- R8: B elements belonging to inactive lanes have no effect on the result.
- R9: `in_ready` = !`out_valid` || `out_ready`. A beat accepted in one cycle appears on `out_sum` with `out_valid` high after the next rising clock edge. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sum` hold steady.
- R10: While reset (`rst_n` low, active low) is asserted, and after it, `out_valid` is 0 and `out_sum` is 0 until a beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block can take a beat |
| mode | input | 2 | Element count: 00 one, 01 two, 10 four, 11 reserved |
| opa | input | 16 | Padded operand, 4-bit lanes |
| opb | input | 8 | Packed operand, 2-bit elements |
| out_valid | output | 1 | Result register holds a sum |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 16 | Padded sum, same layout as opa |

## Verification
Two functions can fall in the same cycle: holding a stalled result, and a new operand beat offered at the input. The bench lowers `out_ready` with a result in the register and presents a fresh beat at the same time. It judges that `in_ready` drops and that the old sum stays put. It then raises `out_ready` while the beat is still offered, and judges that draining and accepting happen together, with the new sum replacing the old one on the next edge.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 4;
  localparam int ELEM_W = 3;
  localparam int BEL_W  = 2;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'b00,
    MODE_TWO  = 2'b01,
    MODE_FOUR = 2'b10,
    MODE_RSVD = 2'b11
  } part_mode_e;
endpackage

// File: rtl/pla_lane_map.sv
module pla_lane_map
  import pla_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int E_W     = ELEM_W,
  parameter int B_W     = BEL_W
) (
  input  part_mode_e                 mode,
  input  logic [N_LANES*B_W-1:0]     b_packed,
  output logic [N_LANES-1:0]         lane_act,
  output logic [N_LANES*E_W-1:0]     b_wide
);
  localparam int PAD_B = E_W - B_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    always_comb begin
      lane_act[i] = 1'b0;
      unique case (mode)
        MODE_ONE:  lane_act[i] = (i == 0);
        MODE_TWO:  lane_act[i] = ((i % (N_LANES / 2)) == 0);
        MODE_FOUR: lane_act[i] = 1'b1;
        default:   lane_act[i] = 1'b0;
      endcase
    end
    assign b_wide[i*E_W +: E_W] = {{PAD_B{1'b0}}, b_packed[i*B_W +: B_W]};
  end
endmodule

// File: rtl/pla_lane_add.sv
module pla_lane_add
  import pla_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int L_W     = LANE_W,
  parameter int E_W     = ELEM_W
) (
  input  logic [N_LANES*L_W-1:0] a_pad,
  input  logic [N_LANES*E_W-1:0] b_wide,
  input  logic [N_LANES-1:0]     lane_act,
  output logic [N_LANES*L_W-1:0] sum_pad
);
  localparam int PAD_W = L_W - E_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_add
    logic [E_W-1:0] elem_sum;
    assign elem_sum = a_pad[i*L_W +: E_W] + b_wide[i*E_W +: E_W];
    assign sum_pad[i*L_W +: L_W] = lane_act[i] ? {{PAD_W{1'b0}}, elem_sum}
                                               : '0;
  end
endmodule

// File: rtl/padded_lane_adder.sv
module padded_lane_adder
  import pla_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int L_W     = LANE_W,
  parameter int E_W     = ELEM_W,
  parameter int B_W     = BEL_W,
  localparam int A_W    = N_LANES * L_W,
  localparam int PB_W   = N_LANES * B_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      mode,
  input  logic [A_W-1:0]  opa,
  input  logic [PB_W-1:0] opb,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [A_W-1:0]  out_sum
);
  logic [N_LANES-1:0]     lane_act;
  logic [N_LANES*E_W-1:0] b_wide;
  logic [A_W-1:0]         sum_c;
  logic                   take;

  pla_lane_map #(.N_LANES(N_LANES), .E_W(E_W), .B_W(B_W)) u_map (
    .mode     (part_mode_e'(mode)),
    .b_packed (opb),
    .lane_act (lane_act),
    .b_wide   (b_wide)
  );

  pla_lane_add #(.N_LANES(N_LANES), .L_W(L_W), .E_W(E_W)) u_add (
    .a_pad    (opa),
    .b_wide   (b_wide),
    .lane_act (lane_act),
    .sum_pad  (sum_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_sum   <= sum_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/padded_lane_adder_chk.sv
module padded_lane_adder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  mode,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_sum
);
  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sum[3] == 1'b0 && out_sum[7] == 1'b0 &&
                   out_sum[11] == 1'b0 && out_sum[15] == 1'b0));

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == 2'b11) |=> (out_sum == 16'h0000));

  // R2
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == 2'b00) |=> (out_sum[15:4] == 12'h000));

  // R3
  pair_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == 2'b01) |=>
      (out_sum[7:4] == 4'h0 && out_sum[15:12] == 4'h0));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  idle_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);
endmodule

bind padded_lane_adder padded_lane_adder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mode      (mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum)
);

// File: tb/padded_lane_adder_tb.sv
module padded_lane_adder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  mode = 2'b00;
  logic [15:0] opa = '0;
  logic [7:0]  opb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_sum;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  padded_lane_adder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .opa(opa), .opb(opb), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum)
  );

  // {mode, opa, opb, expected sum}
  localparam int NV = 8;
  localparam logic [41:0] VEC [NV] = '{
    {2'b10, 16'h0000, 8'hE4, 16'h3210},  // R1 R4 zero-extended placement
    {2'b10, 16'h7777, 8'hFF, 16'h2222},  // R7 every lane wraps
    {2'b10, 16'hFFFF, 8'h00, 16'h7777},  // R6 A padding ignored
    {2'b00, 16'h1235, 8'hFE, 16'h0007},  // R2 R8 upper B ignored
    {2'b01, 16'h3456, 8'h36, 16'h0700},  // R3 R7 R8 lane0 wraps to 0
    {2'b11, 16'h1234, 8'hFF, 16'h0000},  // R5 reserved
    {2'b10, 16'h1234, 8'h1B, 16'h1357},  // R1 R4 mixed values
    {2'b01, 16'h0F0F, 8'h11, 16'h0000}   // R6 R7 carry stays in lane
  };

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] m, input logic [15:0] a,
                      input logic [7:0] b);
    @(negedge clk);
    mode = m; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid in reset", {15'd0, out_valid}, 16'h0000);
    check("R10 out_sum in reset", out_sum, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 out_valid after reset", {15'd0, out_valid}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][41:40], VEC[i][39:24], VEC[i][23:16]);
      check($sformatf("R9 valid vec%0d", i), {15'd0, out_valid}, 16'h0001);
      check($sformatf("R1-table vec%0d (R2..R8)", i), out_sum, VEC[i][15:0]);
    end

    // R9 stall while a new beat is offered
    @(negedge clk);
    out_ready = 1'b0;
    mode = 2'b10; opa = 16'h1234; opb = 8'h1B; in_valid = 1'b1;
    @(negedge clk);
    check("R9 stalled sum", out_sum, 16'h1357);
    check("R9 in_ready low on stall", {15'd0, in_ready}, 16'h0000);
    opa = 16'h0000; opb = 8'hE4;
    @(negedge clk);
    check("R9 sum held", out_sum, 16'h1357);
    check("R9 valid held", {15'd0, out_valid}, 16'h0001);
    out_ready = 1'b1;
    #1;
    check("R9 in_ready when draining", {15'd0, in_ready}, 16'h0001);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 drain and accept same edge", out_sum, 16'h3210);
    @(negedge clk);
    check("R9 empties after drain", {15'd0, out_valid}, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule